// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a successive-approximation analog-to-digital converter. A start request opens a conversion. The block clears its approximation register and then works through the bits from the most significant to the least significant. For each bit it places a trial code on the DAC output, waits one cycle for the external comparator to settle, and then keeps or drops the bit. When the last bit has been decided, the finished word goes into a set of output latches. In the same cycle the active-low busy flag returns high. Because the latches hold the earlier word until then, the result carries no pipeline delay.

Two control outputs drive the analog front end. `smp_track` connects the inputs to the sampling capacitors and `cmp_zero` nulls the comparator offset. Both are active while the block is acquiring and both drop for the whole conversion. After each conversion the block stays in acquisition for at least `ACQ_CYCLES` cycles. A request that arrives inside that window is held and served when the window closes. A request that arrives while a conversion is running is discarded.

The sequencer has four states:
- `ST_ACQ`: minimum acquisition window. It is entered from reset and after each conversion.
- `ST_IDLE`: acquiring and ready for a request.
- `ST_SETTLE`: a trial code has just been applied to the DAC.
- `ST_DECIDE`: the comparator is sampled.

The transitions are:
- ACQ→IDLE when the window ends with no request.
- ACQ→SETTLE when the window ends with a request held or present.
- IDLE→SETTLE on a request.
- SETTLE→DECIDE always.
- DECIDE→SETTLE while bits remain.
- DECIDE→ACQ after the last bit.

Top module: `sar_sequencer`

## Requirements
- R1: In the first conversion cycle, `dac_code` equals the cleared register with only its top bit set, that is, value 2^(WIDTH-1).
- R2: Trials run from the top bit down. For step k (k = 0 for the top bit), `dac_code` holds the bits above position WIDTH-1-k as already decided, sets bit WIDTH-1-k to 1, and clears every lower bit.
- R3: `smp_track` and `cmp_zero` are both 1 whenever `busy_n` is 1, and both are 0 whenever `busy_n` is 0.
- R4: `result` does not change while `busy_n` is 0. It keeps the previous conversion's word, which is 0 after reset.
- R5: `busy_n` is 0 for exactly 2*WIDTH consecutive cycles per conversion. It rises in the same cycle that `result` takes the new word.
- R6: A `start_req` pulse during a conversion is ignored. No second conversion follows, and `result` is unchanged.
- R7: `cmp_in` = 1 means the input is at or above `dac_code`, so the bit is kept. The final offset code c is presented as `result` = c XOR 2^(WIDTH-1), which is two's complement.
- R8: After each conversion, `busy_n` stays 1 for at least `ACQ_CYCLES` cycles. A request made during that window starts a conversion exactly `ACQ_CYCLES` cycles after `busy_n` rose.
- R9: Each trial code is held for two cycles. `cmp_in` is used only in the second cycle, and its value in the first cycle has no effect.
- R10: After reset, `busy_n`=1, `smp_track`=1, `cmp_zero`=1, `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Conversion request, sampled each cycle |
| cmp_in | input | 1 | Comparator decision: 1 if the input is at or above the DAC code |
| dac_code | output | WIDTH | Offset-binary trial code for the DAC |
| smp_track | output | 1 | 1 = sampling capacitors connected to the inputs |
| cmp_zero | output | 1 | 1 = comparator zeroing switches closed |
| busy_n | output | 1 | 0 while a conversion runs; rises when the result is valid |
| result | output | WIDTH | Latched two's-complement conversion word |

## Verification
On every cycle the assertions check several properties:
- the result stays stable and the conversion length stays bounded while busy is low;
- busy rises after exactly 2*WIDTH cycles;
- the acquisition window before each busy fall is long enough;
- the register is cleared to the top-bit trial at each start;
- the DAC code is steady in each decision cycle.

Only the bench's scenarios can show the following:
- the correctness of the converted value for every input code, with the comparator deliberately wrong in each settling cycle;
- the exact trial sequence;
- that requests made mid-conversion are discarded;
- that early requests are deferred by the right number of cycles.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_ACQ    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_DECIDE = 2'd3
    } sar_state_e;

endpackage

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
    parameter int ACQ_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(ACQ_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(ACQ_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       acq_done,
    input  logic       last_bit,
    output sar_state_e state,
    output logic       conv_start,
    output logic       decide,
    output logic       load_en,
    output logic       acquiring
);
    sar_state_e state_d;
    logic       pend;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ACQ;
        end else begin
            state <= state_d;
        end
    end

    // A request during the acquisition window is remembered; one during
    // conversion is dropped because pend is only written in ST_ACQ.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (state == ST_ACQ) begin
            if (start_req) pend <= 1'b1;
        end else begin
            pend <= 1'b0;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_ACQ:    if (acq_done) state_d = (pend || start_req) ? ST_SETTLE : ST_IDLE;
            ST_IDLE:   if (start_req) state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_DECIDE;
            ST_DECIDE: state_d = last_bit ? ST_ACQ : ST_SETTLE;
            default:   state_d = ST_ACQ;
        endcase
    end

    // Output logic
    always_comb begin
        conv_start = 1'b0;
        decide     = 1'b0;
        load_en    = 1'b0;
        acquiring  = 1'b0;
        unique case (state)
            ST_ACQ: begin
                acquiring  = 1'b1;
                conv_start = acq_done && (pend || start_req);
            end
            ST_IDLE: begin
                acquiring  = 1'b1;
                conv_start = start_req;
            end
            ST_SETTLE: ;
            ST_DECIDE: begin
                decide  = 1'b1;
                load_en = last_bit;
            end
            default: ;
        endcase
    end

    // R9: a decision cycle always follows a settling cycle
    a_r9_decide_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE) |-> ($past(state) == ST_SETTLE));

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             decide,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] dac_code,
    output logic             last_bit,
    output logic [WIDTH-1:0] final_code
);
    localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [WIDTH-1:0] TOP_ONE = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [PW-1:0]    TOP_IDX = PW'(WIDTH - 1);

    logic [WIDTH-1:0] sar;
    logic [WIDTH-1:0] kept;
    logic [WIDTH-1:0] sar_d;
    logic [PW-1:0]    ptr;

    // Decision on the bit under trial, then arm the next lower bit
    always_comb begin
        kept = sar;
        if (!cmp_in) kept[ptr] = 1'b0;
        sar_d = kept;
        if (ptr != '0) sar_d[ptr - 1'b1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar <= '0;
            ptr <= '0;
        end else if (conv_start) begin
            sar <= TOP_ONE;
            ptr <= TOP_IDX;
        end else if (decide) begin
            sar <= sar_d;
            if (ptr != '0) ptr <= ptr - 1'b1;
        end
    end

    assign dac_code   = sar;
    assign last_bit   = (ptr == '0);
    assign final_code = kept;

    // R1: register cleared with only the top trial bit at every start
    a_r1_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> (dac_code == TOP_ONE));

    // R9: the code seen by the comparator is unchanged in the sampling cycle
    a_r9_code_settled: assert property (@(posedge clk) disable iff (!rst_n)
        decide |-> $stable(dac_code));

endmodule

// File: rtl/sar_out_latch.sv
module sar_out_latch #(
    parameter int WIDTH     = 12,
    parameter bit TWOS_COMP = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] code_in,
    output logic [WIDTH-1:0] result
);
    localparam logic [WIDTH-1:0] TOP_ONE = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] formatted;

    generate
        if (TWOS_COMP) begin : g_twos
            assign formatted = code_in ^ TOP_ONE;
        end else begin : g_offset
            assign formatted = code_in;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (load) begin
            result <= formatted;
        end
    end

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int WIDTH      = 12,
    parameter int ACQ_CYCLES = 4,
    parameter bit TWOS_COMP  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] dac_code,
    output logic             smp_track,
    output logic             cmp_zero,
    output logic             busy_n,
    output logic [WIDTH-1:0] result
);
    localparam int CONV_CYCLES = 2 * WIDTH;

    sar_state_e       state;
    logic             conv_start;
    logic             decide;
    logic             load_en;
    logic             acquiring;
    logic             acq_done;
    logic             last_bit;
    logic [WIDTH-1:0] final_code;

    sar_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .acq_done   (acq_done),
        .last_bit   (last_bit),
        .state      (state),
        .conv_start (conv_start),
        .decide     (decide),
        .load_en    (load_en),
        .acquiring  (acquiring)
    );

    sar_acq_timer #(.ACQ_CYCLES(ACQ_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_ACQ),
        .done  (acq_done)
    );

    sar_bit_engine #(.WIDTH(WIDTH)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .decide     (decide),
        .cmp_in     (cmp_in),
        .dac_code   (dac_code),
        .last_bit   (last_bit),
        .final_code (final_code)
    );

    sar_out_latch #(.WIDTH(WIDTH), .TWOS_COMP(TWOS_COMP)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_en),
        .code_in (final_code),
        .result  (result)
    );

    assign busy_n    = acquiring;
    assign smp_track = acquiring;
    assign cmp_zero  = acquiring;

    // Run-length counters for busy low/high windows
    logic [15:0] low_cnt;
    logic [15:0] high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= '0;
        end else begin
            low_cnt <= busy_n ? 16'd0 : low_cnt + 16'd1;
            if (!busy_n)              high_cnt <= '0;
            else if (high_cnt != '1)  high_cnt <= high_cnt + 16'd1;
        end
    end

    // R4: latched word frozen while converting
    a_r4_result_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n) |-> $stable(result));

    // R5 / R6: a conversion never runs longer than its bit budget
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n) |-> (low_cnt < 16'(CONV_CYCLES)));

    // R5: busy returns high exactly after 2*WIDTH cycles
    a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (low_cnt == 16'(CONV_CYCLES)));

    // R8: acquisition window honoured before each conversion
    a_r8_min_acquire: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> (high_cnt >= 16'(ACQ_CYCLES)));

endmodule

// File: tb/sim_sar_sequencer.sv
`timescale 1ns/1ps
module sim_sar_sequencer;
    localparam int W   = 8;
    localparam int ACQ = 3;
    localparam int TOP = 1 << (W - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_req = 1'b0;
    logic         cmp_in = 1'b0;
    logic [W-1:0] dac_code;
    logic         smp_track, cmp_zero, busy_n;
    logic [W-1:0] result;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int exp_prev = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sar_sequencer #(.WIDTH(W), .ACQ_CYCLES(ACQ), .TWOS_COMP(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .cmp_in(cmp_in),
        .dac_code(dac_code), .smp_track(smp_track), .cmp_zero(cmp_zero),
        .busy_n(busy_n), .result(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Entered at the first negedge of a conversion. inject: pulse a request mid-way.
    task automatic do_steps(input int v, input bit inject);
        for (int j = 1; j <= 2 * W; j++) begin
            int k = (j - 1) / 2;
            int hi_mask = ((1 << W) - 1) & ~((1 << (W - k)) - 1);
            int exp_code = (v & hi_mask) | (1 << (W - 1 - k));
            bit right = (v >= exp_code);
            if (j == 1) chk(int'(dac_code) == TOP, "R1", int'(dac_code), TOP);
            chk(int'(dac_code) == exp_code, "R2", int'(dac_code), exp_code);
            chk(busy_n == 1'b0, "R5", int'(busy_n), 0);
            chk(!smp_track && !cmp_zero, "R3", int'({smp_track, cmp_zero}), 0);
            chk(int'(result) == exp_prev, "R4", int'(result), exp_prev);
            // R9: wrong decision offered in settling cycles
            cmp_in = (j % 2 == 1) ? ~right : right;
            start_req = inject && (j == 3);
            @(negedge clk);
            start_req = 1'b0;
        end
        exp_prev = v ^ TOP;
        chk(busy_n == 1'b1, "R5", int'(busy_n), 1);
        chk(int'(result) == exp_prev, "R7", int'(result), exp_prev);
        chk(smp_track && cmp_zero, "R3", int'({smp_track, cmp_zero}), 3);
    endtask

    task automatic start_now(input int v);
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        do_steps(v, 1'b0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_n && smp_track && cmp_zero && result == '0, "R10",
            int'({busy_n, smp_track, cmp_zero}), 7);
        rst_n = 1'b1;
        repeat (ACQ + 1) @(negedge clk);

        // Exhaustive sweep of every input code (R1, R2, R7, R9)
        for (int v = 0; v < (1 << W); v++) begin
            start_now(v);
            repeat (ACQ) @(negedge clk);
        end

        // R6: request in the middle of a conversion is dropped
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        do_steps(37, 1'b1);
        for (int i = 0; i < ACQ + 4; i++) begin
            chk(busy_n == 1'b1, "R6", int'(busy_n), 1);
            chk(int'(result) == (37 ^ TOP), "R6", int'(result), 37 ^ TOP);
            @(negedge clk);
        end

        // R8: request right after completion waits out the window
        start_now(200);
        begin
            int hcount = 1;
            start_req = 1'b1;
            @(negedge clk);
            start_req = 1'b0;
            while (busy_n && hcount < 50) begin
                hcount++;
                @(negedge clk);
            end
            chk(hcount == ACQ, "R8", hcount, ACQ);
        end
        do_steps(91, 1'b0);

        // Extremes of the range (R7)
        repeat (ACQ) @(negedge clk);
        start_now(0);
        chk(int'(result) == TOP, "R7", int'(result), TOP);
        repeat (ACQ) @(negedge clk);
        start_now((1 << W) - 1);
        chk(int'(result) == TOP - 1, "R7", int'(result), TOP - 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule